// File: doc/BRIEF.md
# Dual Stepper Motor Phase Sequencer

This block produces the four-phase drive words for two stepper motors, one moving the scanner and one moving the printer. Each phase output goes to an external current driver. Software writes a short table of 4-bit drive words for each motor and the length of the cycle through that table. It also picks one of four shared line-time slots that sets how often a motor may take a step. A step-request pulse and a direction level per motor move the table index forward or backward. The index moves once at the next line tick and wraps at the programmed length.

A power-timeout counter counts line ticks on which a powered motor takes no step. When the count reaches the programmed limit, the block drops that motor's power-enable output and forces its phases low. The next request restores power on the same table entry. Either motor can instead be placed in general-purpose mode. In that mode its four outputs show a register value directly.

Configuration is a write-only register port. The register map has 7 address bits and 16 data bits:
- Addresses 0x40 to 0x43 hold the four 16-bit line-time slots.
- Each motor has a 32-address window: the scanner at 0x00, the printer at 0x20.
- Within a window, offsets 0x00 to 0x07 are the table entries (data bits 3:0).
- Offset 0x08 holds the cycle length minus one (bits 2:0).
- Offset 0x09 is control: bit 0 enable, bit 1 general-purpose mode, bits 3:2 line-slot select.
- Offset 0x0A holds the general-purpose output value (bits 3:0).
- Offset 0x0B holds the idle-tick limit (16 bits, where 0 means never).

Top module: `dual_stepper_seq`

## Requirements
- R1: After reset, all eight phase outputs and both power-enable outputs are low.
- R2: Once a motor is enabled (control bit 0) and powered, each step it takes drives its phase outputs with the table entry at the new index. The table entries sit at window offsets 0x00 to 0x07. The first request from reset powers the motor on entry 0.
- R3: A step request is held pending and acted on only at the motor's next line tick. Several requests between two ticks produce a single step.
- R4: With direction low the index increments, and from (length-1) it returns to 0. With direction high the index decrements, and from 0 it goes to (length-1). The length field at offset 0x08 holds length-1.
- R5: The line tick period is the selected slot value × PRESCALE clock cycles, and a slot value of 0 counts as 1. A request held high steps once per tick.
- R6: When a powered motor sees (limit) consecutive ticks with no step, its power output goes low and its phases go to 0. The limit sits at offset 0x0B, and a limit of 0 never times out.
- R7: The first request after a timeout restores power and drives the same table entry as before the timeout, without advancing.
- R8: In general-purpose mode (control bit 1) the phases equal the offset 0x0A value and power is low. Requests are ignored, and leaving the mode resumes at the unchanged index.
- R9: The two motors are independent: requests, direction and configuration of one never change the other's outputs.
- R10: With the enable bit low, a motor's phases and power are low and its requests are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 16 | Register write data |
| scan_step | input | 1 | Scanner step request |
| scan_dir | input | 1 | Scanner direction (1 = backward) |
| prn_step | input | 1 | Printer step request |
| prn_dir | input | 1 | Printer direction (1 = backward) |
| scan_phase | output | 4 | Scanner phase drive word |
| prn_phase | output | 4 | Printer phase drive word |
| scan_pwr | output | 1 | Scanner driver power enable |
| prn_pwr | output | 1 | Printer driver power enable |

## Verification
A wrong table index shows up as a wrong phase word two clocks after the line tick that moved it. The bench therefore compares phase words against a computed walk through the table, including both wrap points. A tick counter off by one shows up directly as the spacing between phase changes under a held request, measured in clocks. An error in the idle counter or the wake logic shows up one tick late or early as the power output falling, or as a resumed word that differs from the last one seen.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int MOTORS = 2;
  localparam int PH_W   = 4;
  localparam int ENT    = 8;
  localparam int IDX_W  = $clog2(ENT);
  localparam int CNT_W  = 16;
  localparam int SLOTS  = 4;
  localparam int SEL_W  = $clog2(SLOTS);
  localparam int ADDR_W = 7;

  typedef struct packed {
    logic [IDX_W-1:0] len_m1;
    logic             en;
    logic             gpo;
    logic [SEL_W-1:0] sel;
    logic [PH_W-1:0]  gpo_val;
    logic [CNT_W-1:0] to_lim;
  } stp_cfg_t;
endpackage

// File: rtl/stp_prescaler.sv
module stp_prescaler #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst,
  output logic strobe_o
);
  localparam int PC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PC_W-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q   <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= (pcnt_q == PC_W'(PRESCALE - 1));
      pcnt_q   <= (pcnt_q == PC_W'(PRESCALE - 1)) ? '0 : pcnt_q + 1'b1;
    end
  end

  generate
    if (PRESCALE > 1) begin : g_gap_chk
      a_r5_strobe_gap: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> !strobe_o);
    end
  endgenerate
endmodule

// File: rtl/stp_regfile.sv
module stp_regfile
  import stp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output stp_cfg_t          cfg_o   [MOTORS],
  output logic [CNT_W-1:0]  slot_o  [SLOTS],
  output logic [MOTORS-1:0] tbl_we_o,
  output logic [IDX_W-1:0]  tbl_wa_o,
  output logic [PH_W-1:0]   tbl_wd_o
);
  localparam logic [4:0] OFF_LEN = 5'h08;
  localparam logic [4:0] OFF_CTL = 5'h09;
  localparam logic [4:0] OFF_GPO = 5'h0A;
  localparam logic [4:0] OFF_TO  = 5'h0B;

  logic       slot_space;
  logic [4:0] off;

  assign slot_space = wr_addr[6];
  assign off        = wr_addr[4:0];
  assign tbl_wa_o   = wr_addr[IDX_W-1:0];
  assign tbl_wd_o   = wr_data[PH_W-1:0];

  genvar s, m;
  generate
    for (s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) slot_o[s] <= '0;
        else if (wr_en && slot_space && wr_addr[SEL_W-1:0] == SEL_W'(s))
          slot_o[s] <= wr_data;
      end
    end

    for (m = 0; m < MOTORS; m++) begin : g_mot
      logic hit;
      assign hit = wr_en && !slot_space && (wr_addr[5] == 1'(m));
      assign tbl_we_o[m] = hit && (off[4:3] == 2'b00);

      always_ff @(posedge clk) begin
        if (rst) begin
          cfg_o[m].len_m1  <= IDX_W'(ENT - 1);
          cfg_o[m].en      <= 1'b0;
          cfg_o[m].gpo     <= 1'b0;
          cfg_o[m].sel     <= '0;
          cfg_o[m].gpo_val <= '0;
          cfg_o[m].to_lim  <= '0;
        end else if (hit) begin
          case (off)
            OFF_LEN: cfg_o[m].len_m1 <= wr_data[IDX_W-1:0];
            OFF_CTL: begin
              cfg_o[m].en  <= wr_data[0];
              cfg_o[m].gpo <= wr_data[1];
              cfg_o[m].sel <= wr_data[2 +: SEL_W];
            end
            OFF_GPO: cfg_o[m].gpo_val <= wr_data[PH_W-1:0];
            OFF_TO:  cfg_o[m].to_lim  <= wr_data;
            default: ;
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/stp_channel.sv
module stp_channel
  import stp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             step_req,
  input  logic             dir,
  input  stp_cfg_t         cfg,
  input  logic [CNT_W-1:0] lt_val,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_wa,
  input  logic [PH_W-1:0]  tbl_wd,
  output logic [PH_W-1:0]  phase_o,
  output logic             pwr_o
);
  logic             run;
  logic [CNT_W-1:0] lt_m1;
  logic [CNT_W-1:0] tcnt_q;
  logic             tick;
  logic             pend_q;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             powered_q;
  logic [CNT_W-1:0] idle_q;
  logic [PH_W-1:0]  tbl_q [ENT];
  logic [PH_W-1:0]  pat_q;

  assign run   = cfg.en && !cfg.gpo;
  assign lt_m1 = (lt_val == '0) ? '0 : lt_val - 1'b1;
  assign tick  = run && strobe && (tcnt_q >= lt_m1);

  // line-time counter in prescaled strobes
  always_ff @(posedge clk) begin
    if (rst || !run)  tcnt_q <= '0;
    else if (strobe)  tcnt_q <= tick ? '0 : tcnt_q + 1'b1;
  end

  // pending request, consumed by a tick
  always_ff @(posedge clk) begin
    if (rst || !run) pend_q <= 1'b0;
    else             pend_q <= (pend_q && !tick) || step_req;
  end

  always_comb begin
    if (!dir) idx_nxt = (idx_q >= cfg.len_m1) ? '0 : idx_q + 1'b1;
    else      idx_nxt = (idx_q == '0 || idx_q > cfg.len_m1) ? cfg.len_m1 : idx_q - 1'b1;
  end

  // index, power state and idle-tick timeout
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      powered_q <= 1'b0;
      idle_q    <= '0;
    end else if (!cfg.en) begin
      powered_q <= 1'b0;
      idle_q    <= '0;
    end else if (tick) begin
      if (pend_q) begin
        idle_q <= '0;
        if (!powered_q) powered_q <= 1'b1;
        else            idx_q     <= idx_nxt;
      end else if (powered_q && cfg.to_lim != '0) begin
        if (idle_q == cfg.to_lim - 1'b1) begin
          powered_q <= 1'b0;
          idle_q    <= '0;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end
    end
  end

  // pattern table: synchronous write and read
  always_ff @(posedge clk) begin
    if (tbl_we) tbl_q[tbl_wa] <= tbl_wd;
    pat_q <= tbl_q[idx_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= '0;
      pwr_o   <= 1'b0;
    end else begin
      pwr_o <= run && powered_q;
      if (cfg.gpo)                  phase_o <= cfg.gpo_val;
      else if (run && powered_q)    phase_o <= pat_q;
      else                          phase_o <= '0;
    end
  end

  a_r3_move_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(idx_q) |-> $past(tick));

  a_r4_fwd_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && pend_q && powered_q && !dir && idx_q == cfg.len_m1) |=> (idx_q == '0));

  a_r6_sleep_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(powered_q) |-> ($past(tick) || !$past(cfg.en)));

  a_r7_wake_keeps_index: assert property (@(posedge clk) disable iff (rst)
    (tick && pend_q && !powered_q) |=> (powered_q && $stable(idx_q)));

  a_r8_gpo_outputs: assert property (@(posedge clk) disable iff (rst)
    $past(cfg.gpo) |-> (!pwr_o && phase_o == $past(cfg.gpo_val)));
endmodule

// File: rtl/dual_stepper_seq.sv
module dual_stepper_seq
  import stp_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [6:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        scan_step,
  input  logic        scan_dir,
  input  logic        prn_step,
  input  logic        prn_dir,
  output logic [3:0]  scan_phase,
  output logic [3:0]  prn_phase,
  output logic        scan_pwr,
  output logic        prn_pwr
);
  stp_cfg_t          cfg    [MOTORS];
  logic [CNT_W-1:0]  slot   [SLOTS];
  logic [MOTORS-1:0] tbl_we;
  logic [IDX_W-1:0]  tbl_wa;
  logic [PH_W-1:0]   tbl_wd;
  logic              strobe;
  logic [MOTORS-1:0] step_v, dir_v, pwr_v;
  logic [PH_W-1:0]   phase_v [MOTORS];

  assign step_v = {prn_step, scan_step};
  assign dir_v  = {prn_dir, scan_dir};

  stp_prescaler #(.PRESCALE(PRESCALE)) i_pre (
    .clk(clk), .rst(rst), .strobe_o(strobe)
  );

  stp_regfile i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_o(cfg), .slot_o(slot), .tbl_we_o(tbl_we), .tbl_wa_o(tbl_wa), .tbl_wd_o(tbl_wd)
  );

  genvar m;
  generate
    for (m = 0; m < MOTORS; m++) begin : g_ch
      stp_channel i_ch (
        .clk(clk), .rst(rst), .strobe(strobe),
        .step_req(step_v[m]), .dir(dir_v[m]), .cfg(cfg[m]),
        .lt_val(slot[cfg[m].sel]),
        .tbl_we(tbl_we[m]), .tbl_wa(tbl_wa), .tbl_wd(tbl_wd),
        .phase_o(phase_v[m]), .pwr_o(pwr_v[m])
      );
    end
  endgenerate

  assign scan_phase = phase_v[0];
  assign prn_phase  = phase_v[1];
  assign scan_pwr   = pwr_v[0];
  assign prn_pwr    = pwr_v[1];

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (scan_phase == '0 && prn_phase == '0 && !scan_pwr && !prn_pwr));
endmodule

// File: tb/test_dual_stepper_seq.sv
module test_dual_stepper_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_STEP  = 48;
  localparam int NVEC       = 13;

  // {motor(0 scan,1 prn), dir, expected scan phase, expected printer phase}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'h1, 4'h0},
    {1'b0, 1'b0, 4'h2, 4'h0},
    {1'b0, 1'b0, 4'h4, 4'h0},
    {1'b0, 1'b0, 4'h8, 4'h0},
    {1'b0, 1'b0, 4'h1, 4'h0},
    {1'b0, 1'b1, 4'h8, 4'h0},
    {1'b0, 1'b1, 4'h4, 4'h0},
    {1'b1, 1'b0, 4'h4, 4'h1},
    {1'b1, 1'b1, 4'h4, 4'h9},
    {1'b1, 1'b1, 4'h4, 4'h8},
    {1'b1, 1'b0, 4'h4, 4'h9},
    {1'b1, 1'b0, 4'h4, 4'h1},
    {1'b0, 1'b0, 4'h8, 4'h1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        scan_step = 1'b0, scan_dir = 1'b0, prn_step = 1'b0, prn_dir = 1'b0;
  logic [3:0]  scan_phase, prn_phase;
  logic        scan_pwr, prn_pwr;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_stepper_seq #(.PRESCALE(4)) i_dual_stepper_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .scan_step(scan_step), .scan_dir(scan_dir), .prn_step(prn_step), .prn_dir(prn_dir),
    .scan_phase(scan_phase), .prn_phase(prn_phase), .scan_pwr(scan_pwr), .prn_pwr(prn_pwr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic mot, input logic d);
    @(negedge clk);
    if (mot) begin prn_dir = d; prn_step = 1'b1; end
    else     begin scan_dir = d; scan_step = 1'b1; end
    @(negedge clk);
    scan_step = 1'b0; prn_step = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // waits for the scanner phase word to change; returns cycles waited
  task automatic wait_scan_change(output int n);
    logic [3:0] prev;
    prev = scan_phase;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (scan_phase == prev && n < 300);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [3:0] held;
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk("R1 scan phase", {12'h0, scan_phase}, 16'h0);
    chk("R1 prn phase",  {12'h0, prn_phase},  16'h0);
    chk("R1 power",      {14'h0, scan_pwr, prn_pwr}, 16'h0);

    // tables: scanner 1,2,4,8 then F filler (length 4); printer half-step (length 8)
    wr(7'h00, 16'h1); wr(7'h01, 16'h2); wr(7'h02, 16'h4); wr(7'h03, 16'h8);
    for (int i = 4; i < 8; i++) wr(7'(i), 16'hF);
    wr(7'h08, 16'h3);
    wr(7'h20, 16'h1); wr(7'h21, 16'h3); wr(7'h22, 16'h2); wr(7'h23, 16'h6);
    wr(7'h24, 16'h4); wr(7'h25, 16'hC); wr(7'h26, 16'h8); wr(7'h27, 16'h9);
    wr(7'h40, 16'd5); wr(7'h41, 16'd3); wr(7'h42, 16'd7);

    // R10 request while disabled is dropped
    pulse(1'b0, 1'b0);
    idle(WAIT_STEP);
    chk("R10 disabled phase", {12'h0, scan_phase}, 16'h0);
    chk("R10 disabled power", {15'h0, scan_pwr}, 16'h0);

    wr(7'h09, 16'h1);   // scanner enable, slot 0
    wr(7'h29, 16'h5);   // printer enable, slot 1
    idle(WAIT_STEP);
    chk("R10 request not kept", {12'h0, scan_phase}, 16'h0);

    // R2 R4 R9 vector walk
    for (int v = 0; v < NVEC; v++) begin
      pulse(VEC[v][9], VEC[v][8]);
      idle(WAIT_STEP);
      chk($sformatf("R2/R4 vec%0d scan", v), {12'h0, scan_phase}, {12'h0, VEC[v][7:4]});
      chk($sformatf("R9 vec%0d prn", v),     {12'h0, prn_phase},  {12'h0, VEC[v][3:0]});
    end
    chk("R2 powers", {14'h0, scan_pwr, prn_pwr}, 16'h3);

    // R3 coalescing: sync to a tick, then three requests before the next one
    pulse(1'b0, 1'b0);
    wait_scan_change(n);
    chk("R3 sync step", {12'h0, scan_phase}, 16'h1);
    pulse(1'b0, 1'b0); pulse(1'b0, 1'b0); pulse(1'b0, 1'b0);
    idle(WAIT_STEP);
    chk("R3 single step", {12'h0, scan_phase}, 16'h2);

    // R5 tick period under a held request
    @(negedge clk); scan_dir = 1'b0; scan_step = 1'b1;
    wait_scan_change(n);
    wait_scan_change(n);
    chk("R5 period slot0", 16'(n), 16'd20);
    wr(7'h09, 16'h9);   // slot 2
    wait_scan_change(n);
    wait_scan_change(n);
    wait_scan_change(n);
    chk("R5 period slot2", 16'(n), 16'd28);
    chk("R9 printer still", {12'h0, prn_phase}, 16'h1);

    // R6 timeout after 3 idle ticks
    wr(7'h0B, 16'd3);
    @(negedge clk); scan_step = 1'b0;
    idle(40);
    held = scan_phase;
    chk("R6 still powered", {15'h0, scan_pwr}, 16'h1);
    idle(120);
    chk("R6 power off", {15'h0, scan_pwr}, 16'h0);
    chk("R6 phases off", {12'h0, scan_phase}, 16'h0);

    // R7 wake resumes the same entry
    pulse(1'b0, 1'b0);
    idle(40);
    chk("R7 power back", {15'h0, scan_pwr}, 16'h1);
    chk("R7 same entry", {12'h0, scan_phase}, {12'h0, held});

    // R8 printer in general-purpose mode
    wr(7'h2A, 16'hA);
    wr(7'h29, 16'h7);
    idle(4);
    chk("R8 gpo value", {12'h0, prn_phase}, 16'hA);
    chk("R8 gpo power", {15'h0, prn_pwr}, 16'h0);
    pulse(1'b1, 1'b0);
    idle(WAIT_STEP);
    chk("R8 request ignored", {12'h0, prn_phase}, 16'hA);
    wr(7'h29, 16'h5);
    idle(4);
    chk("R8 resume index", {12'h0, prn_phase}, 16'h1);
    chk("R8 resume power", {15'h0, prn_pwr}, 16'h1);

    // R10 disable forces outputs low
    wr(7'h09, 16'h0);
    idle(4);
    chk("R10 disable phase", {12'h0, scan_phase}, 16'h0);
    chk("R10 disable power", {15'h0, scan_pwr}, 16'h0);
    chk("R9 printer unaffected", {12'h0, prn_phase}, 16'h1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule